// File: doc/BRIEF.md
# Register Bitfield Operation Unit

This unit carries out the eight bitfield operations of a processor's integer pipeline on a single 32-bit data register. A field is described by a starting offset and a width. Bit position 0 of the offset is the register's most significant bit, and the field runs toward the least significant bit. A field that runs past bit 0 continues at bit 31, so the field is circular. Offset and width each come either from an immediate in the low twelve bits of the extension word or from a data register. The register file outside reads those registers and supplies only their low five bits. The register file also selects the second data register, which receives extracted values or supplies the value to insert.

One shared datapath handles all eight operations. It first rotates the operand so that the field sits at the most significant end, and masks it there. The results are produced from that aligned view. The operations that modify the register rotate the mask back into place. The result and flags are combinational. An optional output register stage, enabled by default, returns them one cycle after the request.

Top module: `bitfield_unit`

## Requirements
- R1: The operation code is 3 bits: 0 test, 1 extract unsigned, 2 change, 3 extract signed, 4 clear, 5 find first one, 6 set, 7 insert. `opnd_we` is high only for codes 2, 4, 6 and 7, and `data_we` only for codes 1, 3 and 5. For test, neither register changes: `opnd_out` equals `opnd_in` and `data_out` equals `data_in`.
- R2: When `ext_word[11]` is 1, the offset is `off_dyn`, which is the register value modulo 32. When it is 0, the offset is the immediate `ext_word[10:6]`.
- R3: When `ext_word[5]` is 1, the width code is `wid_dyn`. When it is 0, the width code is `ext_word[4:0]`. The width is ((code-1) mod 32)+1, so code 0 means a width of 32.
- R4: Offset 0 selects bit 31. Field bit i sits at register bit 31-((offset+i) mod 32), so a field that passes bit 0 wraps to bit 31.
- R5: Extract unsigned writes the field, zero-extended and right-justified, to `data_out`.
- R6: Extract signed writes the field, sign-extended from its first bit and right-justified, to `data_out`.
- R7: Find first one writes the offset plus the number of 0 bits that precede the first 1 in the field. If the field holds no 1, it writes the offset plus the width.
- R8: Change, clear and set respectively invert, zero and force to one exactly the field bits of the operand. All other operand bits are unchanged.
- R9: Insert places the low width bits of `data_in` into the field, with the most significant of those bits at field bit 0. All other operand bits are unchanged.
- R10: For all operations except insert, N is the first field bit, and Z is 1 exactly when every field bit is 0.
- R11: For insert, N is bit width-1 of `data_in`, and Z is 1 exactly when the low width bits of `data_in` are all 0.
- R12: `flag_v` and `flag_c` are 0 for every operation.
- R13: With the output register stage, results and `out_valid` appear on the cycle after `in_valid`. The outputs hold while `in_valid` is low. Reset clears `out_valid` and all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present; clock enable for the output stage |
| op | input | 3 | Operation code |
| ext_word | input | 12 | Low bits of the extension word: offset source, offset, width source, width |
| opnd_in | input | 32 | Operand register value |
| data_in | input | 32 | Second data register value (insert source, extract target) |
| off_dyn | input | 5 | Low five bits of the offset register |
| wid_dyn | input | 5 | Low five bits of the width register |
| out_valid | output | 1 | Result present |
| opnd_we | output | 1 | Operand register is to be written |
| data_we | output | 1 | Second register is to be written |
| opnd_out | output | 32 | New operand register value |
| data_out | output | 32 | New second register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag, always 0 |

## Verification
The embedded properties are checked on every cycle for every request:
- the decoded width always lies between 1 and 32;
- an unsigned extract never sets a bit above the width;
- the find-first-one result never exceeds offset plus width;
- N and Z are never set together;
- a modifying operation changes no bit outside the rotated mask;
- `out_valid` tracks `in_valid` with one cycle of delay.

The remaining behaviour needs the bench's scenarios, which compare each result against a bit-by-bit field model:
- wraparound past bit 0;
- a width code of 0 meaning 32;
- immediate versus register source selection;
- sign extension;
- an empty field in find-first-one;
- the exact flags for insert;
- holding of the outputs between requests.

// File: rtl/bf_pkg.sv
package bf_pkg;

  typedef enum logic [2:0] {
    BF_TST  = 3'd0,
    BF_EXTU = 3'd1,
    BF_CHG  = 3'd2,
    BF_EXTS = 3'd3,
    BF_CLR  = 3'd4,
    BF_FFO  = 3'd5,
    BF_SET  = 3'd6,
    BF_INS  = 3'd7
  } bf_op_e;

  localparam int unsigned BF_XLEN = 32;

endpackage

// File: rtl/bf_fieldsel.sv
// Selects offset and width sources and builds the MSB-aligned field mask.
module bf_fieldsel #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SW = $clog2(XLEN)
) (
  input  logic [11:0]     ext_word,
  input  logic [SW-1:0]   off_dyn,
  input  logic [SW-1:0]   wid_dyn,
  output logic [SW-1:0]   off,
  output logic [SW:0]     wid,
  output logic [XLEN-1:0] mask_msb
);

  logic [SW-1:0] wcode;
  logic [SW-1:0] wm1;

  always_comb begin
    off      = ext_word[11] ? off_dyn : ext_word[6 +: SW];
    wcode    = ext_word[5]  ? wid_dyn : ext_word[0 +: SW];
    wm1      = wcode - SW'(1);
    wid      = {1'b0, wm1} + (SW+1)'(1);
    mask_msb = ~({XLEN{1'b1}} >> wid);
  end

endmodule

// File: rtl/bf_rotate.sv
// Circular rotate; LEFT selects the direction.
module bf_rotate #(
  parameter int unsigned XLEN = 32,
  parameter bit          LEFT = 1'b1,
  localparam int unsigned SW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SW-1:0]   amt,
  output logic [XLEN-1:0] dout
);

  logic [2*XLEN-1:0] dbl;
  logic [2*XLEN-1:0] shifted;

  assign dbl = {din, din};

  generate
    if (LEFT) begin : g_left
      assign shifted = dbl << amt;
      assign dout    = shifted[2*XLEN-1:XLEN];
    end else begin : g_right
      assign shifted = dbl >> amt;
      assign dout    = shifted[XLEN-1:0];
    end
  endgenerate

endmodule

// File: rtl/bf_lzc.sv
// Leading-zero count; all-zero input yields XLEN.
module bf_lzc #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned CW = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0] din,
  output logic [CW-1:0]   cnt
);

  always_comb begin
    cnt = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (din[i]) cnt = CW'(XLEN - 1 - i);
    end
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bf_pkg::*;
#(
  parameter int unsigned XLEN    = BF_XLEN,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned SW = $clog2(XLEN),
  localparam int unsigned CW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [11:0]     ext_word,
  input  logic [XLEN-1:0] opnd_in,
  input  logic [XLEN-1:0] data_in,
  input  logic [SW-1:0]   off_dyn,
  input  logic [SW-1:0]   wid_dyn,
  output logic            out_valid,
  output logic            opnd_we,
  output logic            data_we,
  output logic [XLEN-1:0] opnd_out,
  output logic [XLEN-1:0] data_out,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);

  logic [SW-1:0]   off;
  logic [SW:0]     wid;
  logic [XLEN-1:0] mask_msb;
  logic [XLEN-1:0] opnd_al;
  logic [XLEN-1:0] src_rot;
  logic [XLEN-1:0] field_msb;
  logic [XLEN-1:0] ins_msb;
  logic [XLEN-1:0] place_mask;
  logic [XLEN-1:0] place_ins;
  logic [CW-1:0]   lz_cnt;
  logic [SW:0]     shamt;
  logic [XLEN-1:0] ext_u;
  logic [XLEN-1:0] ext_s;
  logic [XLEN-1:0] ffo_res;
  logic [XLEN-1:0] flag_src;
  bf_op_e          op_e;

  logic            nxt_owe, nxt_dwe, nxt_n, nxt_z;
  logic [XLEN-1:0] nxt_opnd, nxt_data;

  bf_fieldsel #(.XLEN(XLEN)) u_sel (
    .ext_word (ext_word),
    .off_dyn  (off_dyn),
    .wid_dyn  (wid_dyn),
    .off      (off),
    .wid      (wid),
    .mask_msb (mask_msb)
  );

  // Bring the field to the MSB end.
  bf_rotate #(.XLEN(XLEN), .LEFT(1'b1)) u_align (
    .din (opnd_in), .amt (off), .dout (opnd_al)
  );

  // Bring the low width bits of the insert source to the MSB end.
  bf_rotate #(.XLEN(XLEN), .LEFT(1'b0)) u_src (
    .din (data_in), .amt (wid[SW-1:0]), .dout (src_rot)
  );

  assign field_msb = opnd_al & mask_msb;
  assign ins_msb   = src_rot & mask_msb;

  // Return mask and insert value to the field position.
  bf_rotate #(.XLEN(XLEN), .LEFT(1'b0)) u_pmask (
    .din (mask_msb), .amt (off), .dout (place_mask)
  );

  bf_rotate #(.XLEN(XLEN), .LEFT(1'b0)) u_pins (
    .din (ins_msb), .amt (off), .dout (place_ins)
  );

  // Bits below the field are forced to 1, so the count stops at the width.
  bf_lzc #(.XLEN(XLEN)) u_lzc (
    .din (field_msb | ~mask_msb), .cnt (lz_cnt)
  );

  assign op_e    = bf_op_e'(op);
  assign shamt   = (SW+1)'(XLEN) - wid;
  assign ext_u   = field_msb >> shamt;
  assign ext_s   = XLEN'($signed(field_msb) >>> shamt);
  assign ffo_res = XLEN'(off) + XLEN'(lz_cnt);

  always_comb begin
    nxt_opnd = opnd_in;
    nxt_data = data_in;
    nxt_owe  = 1'b0;
    nxt_dwe  = 1'b0;
    unique case (op_e)
      BF_TST:  ;
      BF_EXTU: begin nxt_data = ext_u;   nxt_dwe = 1'b1; end
      BF_EXTS: begin nxt_data = ext_s;   nxt_dwe = 1'b1; end
      BF_FFO:  begin nxt_data = ffo_res; nxt_dwe = 1'b1; end
      BF_CHG:  begin nxt_opnd = opnd_in ^ place_mask;  nxt_owe = 1'b1; end
      BF_CLR:  begin nxt_opnd = opnd_in & ~place_mask; nxt_owe = 1'b1; end
      BF_SET:  begin nxt_opnd = opnd_in | place_mask;  nxt_owe = 1'b1; end
      BF_INS:  begin
        nxt_opnd = (opnd_in & ~place_mask) | place_ins;
        nxt_owe  = 1'b1;
      end
      default: ;
    endcase
    flag_src = (op_e == BF_INS) ? ins_msb : field_msb;
    nxt_n    = flag_src[XLEN-1];
    nxt_z    = ~|flag_src;
  end

  assign flag_v = 1'b0;
  assign flag_c = 1'b0;

  generate
    if (OUT_REG) begin : g_reg
      logic            valid_q, owe_q, dwe_q, n_q, z_q;
      logic [XLEN-1:0] opnd_q, data_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          owe_q   <= 1'b0;
          dwe_q   <= 1'b0;
          n_q     <= 1'b0;
          z_q     <= 1'b0;
          opnd_q  <= '0;
          data_q  <= '0;
        end else begin
          valid_q <= in_valid;
          if (in_valid) begin
            owe_q  <= nxt_owe;
            dwe_q  <= nxt_dwe;
            n_q    <= nxt_n;
            z_q    <= nxt_z;
            opnd_q <= nxt_opnd;
            data_q <= nxt_data;
          end
        end
      end

      assign out_valid = valid_q;
      assign opnd_we   = owe_q;
      assign data_we   = dwe_q;
      assign opnd_out  = opnd_q;
      assign data_out  = data_q;
      assign flag_n    = n_q;
      assign flag_z    = z_q;

      // R13: one-cycle latency of the result strobe
      p_valid_lat_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(opnd_out) && $stable(data_out));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign opnd_we   = nxt_owe;
      assign data_we   = nxt_dwe;
      assign opnd_out  = nxt_opnd;
      assign data_out  = nxt_data;
      assign flag_n    = nxt_n;
      assign flag_z    = nxt_z;
    end
  endgenerate

  // R3: decoded width stays in 1..XLEN
  p_width_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (wid >= (SW+1)'(1)) && (wid <= (SW+1)'(XLEN)));

  // R5: unsigned extract has no bits above the width
  p_extu_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == BF_EXTU && wid < (SW+1)'(XLEN)) |->
      ((nxt_data >> wid) == '0));

  // R7: find-first-one never passes the end of the field
  p_ffo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == BF_FFO) |-> (nxt_data <= XLEN'(off) + XLEN'(wid)));

  // R8: modifying operations leave bits outside the field untouched
  p_outside_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nxt_owe) |-> (((nxt_opnd ^ opnd_in) & ~place_mask) == '0));

  // R10: N and Z are mutually exclusive
  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(nxt_n && nxt_z));

endmodule

// File: tb/test_bitfield_unit.sv
`timescale 1ns/1ps
module test_bitfield_unit;

  typedef struct packed {
    logic        ow;
    logic        dw;
    logic [31:0] o;
    logic [31:0] d;
    logic        n;
    logic        z;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [11:0] ext_word;
  logic [31:0] opnd_in, data_in;
  logic [4:0]  off_dyn, wid_dyn;
  logic        out_valid, opnd_we, data_we;
  logic [31:0] opnd_out, data_out;
  logic        flag_n, flag_z, flag_v, flag_c;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t exp_q[$];
  string tag_q[$];
  exp_t last_exp;

  always #2 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .ext_word(ext_word), .opnd_in(opnd_in), .data_in(data_in),
    .off_dyn(off_dyn), .wid_dyn(wid_dyn), .out_valid(out_valid),
    .opnd_we(opnd_we), .data_we(data_we), .opnd_out(opnd_out),
    .data_out(data_out), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic logic [11:0] mk_ext(input logic oreg, input logic [4:0] oimm,
                                         input logic wreg, input logic [4:0] wimm);
    return {oreg, oimm, wreg, wimm};
  endfunction

  // Bit-by-bit field model
  function automatic exp_t model(input logic [2:0] o, input logic [11:0] e,
                                 input logic [31:0] a, input logic [31:0] d,
                                 input logic [4:0] od, input logic [4:0] wd);
    exp_t r;
    int off, w, ffo, pos;
    logic [63:0] fval, insv, lowm;
    off  = e[11] ? int'(od) : int'(e[10:6]);
    w    = e[5] ? int'(wd) : int'(e[4:0]);
    if (w == 0) w = 32;
    fval = 0;
    ffo  = -1;
    lowm = (64'd1 << w) - 64'd1;
    insv = {32'd0, d} & lowm;
    r.o = a; r.d = d; r.ow = 1'b0; r.dw = 1'b0;
    for (int i = 0; i < w; i++) begin
      pos  = 31 - ((off + i) % 32);
      fval = {fval[62:0], a[pos]};
      if (a[pos] && ffo < 0) ffo = i;
      case (o)
        3'd2: r.o[pos] = ~a[pos];
        3'd4: r.o[pos] = 1'b0;
        3'd6: r.o[pos] = 1'b1;
        3'd7: r.o[pos] = d[w-1-i];
        default: ;
      endcase
    end
    case (o)
      3'd1: begin r.d = fval[31:0]; r.dw = 1'b1; end
      3'd3: begin
        r.d  = fval[w-1] ? (fval[31:0] | ~lowm[31:0]) : fval[31:0];
        r.dw = 1'b1;
      end
      3'd5: begin r.d = 32'(off + ((ffo < 0) ? w : ffo)); r.dw = 1'b1; end
      3'd2, 3'd4, 3'd6, 3'd7: r.ow = 1'b1;
      default: ;
    endcase
    if (o == 3'd7) begin
      r.n = insv[w-1]; r.z = (insv == 0);
    end else begin
      r.n = fval[w-1]; r.z = (fval == 0);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %s expected %s", what, act, expv);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [11:0] e,
                       input logic [31:0] a, input logic [31:0] d,
                       input logic [4:0] od, input logic [4:0] wd, input string tag);
    @(negedge clk);
    in_valid = 1'b1; op = o; ext_word = e; opnd_in = a; data_in = d;
    off_dyn = od; wid_dyn = wd;
    exp_q.push_back(model(o, e, a, d, od, wd));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R13 unexpected result", "valid", "none");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(opnd_out == e.o && data_out == e.d && opnd_we == e.ow &&
              data_we == e.dw && flag_n == e.n && flag_z == e.z &&
              flag_v == 1'b0 && flag_c == 1'b0,
              {t, " R12 result"},
              $sformatf("o=%h d=%h we=%b%b nzvc=%b%b%b%b", opnd_out, data_out,
                        opnd_we, data_we, flag_n, flag_z, flag_v, flag_c),
              $sformatf("o=%h d=%h we=%b%b nzvc=%b%b00", e.o, e.d, e.ow, e.dw,
                        e.n, e.z));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; ext_word = '0;
    opnd_in = '0; data_in = '0; off_dyn = '0; wid_dyn = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(out_valid == 1'b0 && opnd_out == 32'd0 && data_out == 32'd0,
          "R13 reset state", $sformatf("v=%b o=%h d=%h", out_valid, opnd_out, data_out),
          "v=0 o=0 d=0");
    rst_n = 1'b1;
    idle(2);

    // R1 R10: test changes nothing, flags from field
    drive(3'd0, mk_ext(0, 5'd4, 0, 5'd8), 32'h8C3F_0A51, 32'h1234_5678, 0, 0, "R1 R10 test");
    drive(3'd0, mk_ext(0, 5'd16, 0, 5'd4), 32'hFFFF_0FFF, 32'hAAAA_5555, 0, 0, "R10 test zero");
    // R5 R4: unsigned extract, plain and wrapping
    drive(3'd1, mk_ext(0, 5'd0, 0, 5'd12), 32'hA5C3_0F0F, 32'hDEAD_BEEF, 0, 0, "R5 extu");
    drive(3'd1, mk_ext(0, 5'd28, 0, 5'd8), 32'h0000_000B, 32'h0, 0, 0, "R4 extu wrap");
    // R6: signed extract
    drive(3'd3, mk_ext(0, 5'd8, 0, 5'd6), 32'h00A4_0000, 32'h0, 0, 0, "R6 exts neg");
    drive(3'd3, mk_ext(0, 5'd8, 0, 5'd6), 32'h0054_0000, 32'hFFFF_FFFF, 0, 0, "R6 exts pos");
    // R8: change, clear, set
    drive(3'd2, mk_ext(0, 5'd30, 0, 5'd6), 32'h1234_5678, 32'h0, 0, 0, "R8 R4 chg wrap");
    drive(3'd4, mk_ext(0, 5'd8, 0, 5'd0), 32'hFFFF_FFFF, 32'h0, 0, 0, "R8 R3 clr width32");
    drive(3'd6, mk_ext(1, 5'd3, 0, 5'd5), 32'h0000_0000, 32'h0, 5'd21, 0, "R8 R2 set dyn off");
    // R7: find first one
    drive(3'd5, mk_ext(0, 5'd4, 0, 5'd12), 32'h0004_0000, 32'h0, 0, 0, "R7 ffo found");
    drive(3'd5, mk_ext(0, 5'd20, 0, 5'd10), 32'hFFFF_F003, 32'h0, 0, 0, "R7 ffo empty");
    drive(3'd5, mk_ext(0, 5'd28, 0, 5'd8), 32'h0000_0000 | 32'h4000_0000, 32'h0, 0, 0, "R7 R4 ffo wrap");
    // R9 R11: insert
    drive(3'd7, mk_ext(0, 5'd12, 0, 5'd8), 32'hFFFF_FFFF, 32'hFFFF_FF3C, 0, 0, "R9 R11 ins pos");
    drive(3'd7, mk_ext(0, 5'd26, 0, 5'd12), 32'h0000_0000, 32'h0000_0A5A, 0, 0, "R9 R11 ins wrap neg");
    drive(3'd7, mk_ext(0, 5'd0, 0, 5'd4), 32'h5555_5555, 32'hFFFF_FFF0, 0, 0, "R11 ins zero");
    // R3: dynamic width, code 0 and small
    drive(3'd1, mk_ext(0, 5'd0, 1, 5'd3), 32'h9876_5432, 32'h0, 0, 5'd0, "R3 dyn width32");
    drive(3'd1, mk_ext(1, 5'd0, 1, 5'd9), 32'h0F00_0000, 32'h0, 5'd4, 5'd5, "R3 R2 dyn width5");
    idle(4);
    // R13: outputs held while idle
    check(out_valid == 1'b0 && opnd_out == last_exp.o && data_out == last_exp.d,
          "R13 hold", $sformatf("v=%b o=%h d=%h", out_valid, opnd_out, data_out),
          $sformatf("v=0 o=%h d=%h", last_exp.o, last_exp.d));
    check(exp_q.size() == 0, "R13 all results returned",
          $sformatf("%0d left", exp_q.size()), "0 left");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule